// File: doc/BRIEF.md
# SDRAM Bank Window Decoder

This block holds the configuration words of up to four SDRAM banks and turns every incoming 32-bit physical address into a bank selection. For each address it reports whether any bank window claims it, which bank that is, and how far into that bank the address lies. The decode is combinational from the stored configuration. A memory controller can therefore route a request in the same cycle it presents the address.

Each bank configuration word packs three things: a base address aligned to 8 MiB, a power-of-two size code, and a per-bank enable. A separate controller-enable input gates all windows together. Dropping it closes every window at once. Raising it again reopens the windows from the words already stored, so nothing needs to be rewritten.

Configuration words are written one bank at a time through a fixed mask. They can be read back by bank index. When two enabled windows overlap, the bank with the lower index owns the shared addresses.

Top module: `sdram_window_decoder`

## Requirements
- R1: After a synchronous active-low reset, every stored bank configuration word reads back as zero, and no address produces a hit.
- R2: A write to a bank stores the written word ANDed with 0xFFDEE001. Reading that bank index returns the stored word.
- R3: The bank base is config bits 31:23 followed by 23 zero bits. The size code is config bits 19:17, and the window size is 4 MiB shifted left by that code. An address hits when base <= address < base + size, computed without wrapping past the top of the 32-bit space.
- R4: On a hit, the offset output equals the address minus the winning bank's base.
- R5: A bank can hit only while its config bit 0 is 1 and the controller-enable input is 1.
- R6: While controller-enable is 0, no address hits. Once it returns to 1, the windows decode again from the stored words without any rewrite.
- R7: When several banks hit the same address, the bank with the lowest index is reported.
- R8: On a miss, the hit flag, the bank index and the offset outputs are all zero.
- R9: A write changes the read-back word and the decode starting at the first rising clock edge where write-enable is sampled high. Before that edge the old word is still in force.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for a bank configuration word |
| cfg_wr_bank | input | 2 | Bank index being written |
| cfg_wr_data | input | 32 | Configuration word to write (masked on store) |
| cfg_rd_bank | input | 2 | Bank index to read back |
| cfg_rd_data | output | 32 | Stored configuration word of cfg_rd_bank |
| ctrl_enable | input | 1 | Controller enable gating all bank windows |
| addr | input | 32 | Physical address to decode |
| hit | output | 1 | Address falls in an active bank window |
| hit_bank | output | 2 | Index of the winning bank |
| hit_offset | output | 32 | Address minus the winning bank's base |

## Verification
The assertions assume that bank indices on the write and read ports stay within the configured bank count. They also assume that the read-back index is held steady across a write, which lets the stored masked word be observed on the next cycle. The bench only ever drives indices 0 to 3, and it changes write and read indices only on falling edges. Inputs are held stable through each rising edge, and addresses are applied away from the active edge. The sweeps cover the whole 32-bit space at 1 MiB steps plus both sides of every window edge, including a window that would run past the top of the address space.

// File: rtl/sdram_win_pkg.sv
// Shared constants for the SDRAM bank window decoder.
// Assumes 32-bit physical addresses and 32-bit configuration words.
package sdram_win_pkg;
    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned CFG_W       = 32;
    localparam logic [CFG_W-1:0] CFG_KEEP_MASK = 32'hFFDE_E001;
    localparam int unsigned BASE_LSB    = 23;              // window alignment 8 MiB
    localparam int unsigned BASE_W      = CFG_W - BASE_LSB;
    localparam int unsigned SZ_LSB      = 17;
    localparam int unsigned SZ_W        = 3;
    localparam int unsigned EN_BIT      = 0;
    localparam int unsigned MIN_SZ_SH   = 22;              // 4 MiB smallest window
endpackage

// File: rtl/sdram_win_cfg_reg.sv
// One bank configuration register. Stores the written word through the
// fixed keep-mask. Assumes the caller decodes the bank select.
module sdram_win_cfg_reg
    import sdram_win_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wr_data,
    output logic [CFG_W-1:0] cfg_q
);
    // Hold the masked config word; cleared by synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q <= wr_data & CFG_KEEP_MASK;
        end
    end
endmodule

// File: rtl/sdram_win_match.sv
// Window comparator for one bank. Flags a match when the bank and the
// controller are enabled and base <= addr < base + size. The comparison
// is done one bit wider than the address, so windows never wrap.
module sdram_win_match
    import sdram_win_pkg::*;
(
    input  logic [BASE_W-1:0] base_field,
    input  logic [SZ_W-1:0]   size_code,
    input  logic              bank_en,
    input  logic              ctrl_en,
    input  logic [ADDR_W-1:0] addr,
    output logic              match,
    output logic [ADDR_W-1:0] offset
);
    localparam int unsigned EXT_W = ADDR_W + 1;

    logic [EXT_W-1:0] base_ext;
    logic [EXT_W-1:0] size_ext;
    logic [EXT_W-1:0] diff;

    // Form the base address and the window size from the packed fields.
    always_comb begin
        base_ext = {1'b0, base_field, {BASE_LSB{1'b0}}};
        size_ext = EXT_W'(1) << (MIN_SZ_SH + 32'(size_code));
    end

    // Subtract the base; a borrow in the top bit means addr < base.
    always_comb begin
        diff   = {1'b0, addr} - base_ext;
        match  = bank_en && ctrl_en && !diff[ADDR_W] && (diff < size_ext);
        offset = diff[ADDR_W-1:0];
    end
endmodule

// File: rtl/sdram_win_prio.sv
// Fixed-priority selector. Picks the lowest-numbered matching bank and
// passes on its offset. Drives zeros when no bank matches.
module sdram_win_prio
    import sdram_win_pkg::*;
#(
    parameter int unsigned NB    = 4,
    parameter int unsigned IDX_W = 2
) (
    input  logic [NB-1:0]             match,
    input  logic [NB-1:0][ADDR_W-1:0] offsets,
    output logic                      hit,
    output logic [IDX_W-1:0]          hit_idx,
    output logic [ADDR_W-1:0]         hit_off
);
    // Scan from the highest index down so the lowest index is kept last.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        hit_off = '0;
        for (int i = NB - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
                hit_off = offsets[i];
            end
        end
    end
endmodule

// File: rtl/sdram_window_decoder.sv
// Top level of the SDRAM bank window decoder. It holds NUM_BANKS masked
// configuration words and decodes addr combinationally against them.
// The controller-enable input gates every window without touching the
// stored words. Assumes the write and read indices are below NUM_BANKS.
module sdram_window_decoder
    import sdram_win_pkg::*;
#(
    parameter int unsigned NUM_BANKS = 4,
    parameter int unsigned IDX_W     = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [IDX_W-1:0]  cfg_wr_bank,
    input  logic [CFG_W-1:0]  cfg_wr_data,
    input  logic [IDX_W-1:0]  cfg_rd_bank,
    output logic [CFG_W-1:0]  cfg_rd_data,
    input  logic              ctrl_enable,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic [IDX_W-1:0]  hit_bank,
    output logic [ADDR_W-1:0] hit_offset
);
    logic [CFG_W-1:0]             cfg_words [NUM_BANKS];
    logic [NUM_BANKS*CFG_W-1:0]   cfg_flat;
    logic [NUM_BANKS-1:0]         bank_match;
    logic [NUM_BANKS-1:0][ADDR_W-1:0] bank_off;

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic sel_wr;

        // Decode the write strobe for this bank.
        always_comb sel_wr = cfg_wr_en && (cfg_wr_bank == IDX_W'(g));

        sdram_win_cfg_reg u_cfg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (sel_wr),
            .wr_data (cfg_wr_data),
            .cfg_q   (cfg_words[g])
        );

        sdram_win_match u_match (
            .base_field (cfg_words[g][CFG_W-1:BASE_LSB]),
            .size_code  (cfg_words[g][SZ_LSB+SZ_W-1:SZ_LSB]),
            .bank_en    (cfg_words[g][EN_BIT]),
            .ctrl_en    (ctrl_enable),
            .addr       (addr),
            .match      (bank_match[g]),
            .offset     (bank_off[g])
        );

        // Flatten the stored words for the bound checker.
        always_comb cfg_flat[g*CFG_W +: CFG_W] = cfg_words[g];
    end

    // Read-back multiplexer over the stored words.
    always_comb cfg_rd_data = cfg_words[cfg_rd_bank];

    sdram_win_prio #(
        .NB    (NUM_BANKS),
        .IDX_W (IDX_W)
    ) u_prio (
        .match   (bank_match),
        .offsets (bank_off),
        .hit     (hit),
        .hit_idx (hit_bank),
        .hit_off (hit_offset)
    );
endmodule

// File: rtl/sdram_window_decoder_chk.sv
// Assertion checker for sdram_window_decoder, attached by bind below.
// Assumes the read-back index is held steady across a write.
module sdram_window_decoder_chk
    import sdram_win_pkg::*;
#(
    parameter int unsigned NB    = 4,
    parameter int unsigned IDX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_wr_en,
    input logic [IDX_W-1:0]  cfg_wr_bank,
    input logic [CFG_W-1:0]  cfg_wr_data,
    input logic [IDX_W-1:0]  cfg_rd_bank,
    input logic [CFG_W-1:0]  cfg_rd_data,
    input logic              ctrl_enable,
    input logic [ADDR_W-1:0] addr,
    input logic              hit,
    input logic [IDX_W-1:0]  hit_bank,
    input logic [ADDR_W-1:0] hit_offset,
    input logic [NB*CFG_W-1:0] cfg_flat
);
    logic win_en_bit;

    // Enable bit of the bank reported as the winner.
    always_comb win_en_bit = cfg_flat[32'(hit_bank) * CFG_W + EN_BIT];

    // R2: the word written shows up masked on the next cycle.
    p_wr_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr_en |=> (cfg_rd_bank != $past(cfg_wr_bank)) ||
                      (cfg_rd_data == ($past(cfg_wr_data) & CFG_KEEP_MASK)));

    // R4: bases are 8 MiB aligned, so the low offset bits follow the address.
    p_offset_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> (hit_offset[BASE_LSB-1:0] == addr[BASE_LSB-1:0]));

    // R5: a reported bank must have its own enable bit set.
    p_hit_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> win_en_bit);

    // R6: no hit while the controller is disabled.
    p_gate_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_enable |-> !hit);

    // R8: a miss drives index and offset to zero.
    p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_bank == '0) && (hit_offset == '0));
endmodule

bind sdram_window_decoder sdram_window_decoder_chk #(
    .NB    (NUM_BANKS),
    .IDX_W (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cfg_wr_en   (cfg_wr_en),
    .cfg_wr_bank (cfg_wr_bank),
    .cfg_wr_data (cfg_wr_data),
    .cfg_rd_bank (cfg_rd_bank),
    .cfg_rd_data (cfg_rd_data),
    .ctrl_enable (ctrl_enable),
    .addr        (addr),
    .hit         (hit),
    .hit_bank    (hit_bank),
    .hit_offset  (hit_offset),
    .cfg_flat    (cfg_flat)
);

// File: tb/sdram_window_decoder_tb.sv
// Self-checking bench: sweeps addresses against an arithmetic model.
module sdram_window_decoder_tb;
    localparam logic [31:0] MASK = 32'hFFDE_E001;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_bank = '0;
    logic [31:0] cfg_wr_data = '0;
    logic [1:0]  cfg_rd_bank = '0;
    logic [31:0] cfg_rd_data;
    logic        ctrl_enable = 1'b0;
    logic [31:0] addr = '0;
    logic        hit;
    logic [1:0]  hit_bank;
    logic [31:0] hit_offset;

    int vectors = 0;
    int errors  = 0;
    int cycles  = 0;
    logic [31:0] exp_cfg [4];

    always #4 clk = ~clk;   // 125 MHz

    sdram_window_decoder u_dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_wr_en (cfg_wr_en), .cfg_wr_bank (cfg_wr_bank),
        .cfg_wr_data (cfg_wr_data), .cfg_rd_bank (cfg_rd_bank),
        .cfg_rd_data (cfg_rd_data), .ctrl_enable (ctrl_enable),
        .addr (addr), .hit (hit), .hit_bank (hit_bank),
        .hit_offset (hit_offset)
    );

    function automatic logic [31:0] mkcfg(input logic [31:0] base,
                                          input int code, input bit en);
        return (base & 32'hFF80_0000) | (32'(code) << 17) | 32'(en);
    endfunction

    task automatic write_cfg(input int b, input logic [31:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_bank = 2'(b); cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        exp_cfg[b] = d & MASK;
    endtask

    task automatic chk_rd(input string tag, input int b, input logic [31:0] exp);
        cfg_rd_bank = 2'(b);
        #1;
        vectors++;
        if (cfg_rd_data !== exp) begin
            errors++;
            $display("FAIL %s readback bank %0d: got %h expected %h", tag, b, cfg_rd_data, exp);
        end
    endtask

    // Decode check at a falling-edge-aligned time; model from R3..R8.
    task automatic chk_addr(input string tag, input logic [31:0] a);
        bit e_hit; logic [1:0] e_bank; logic [31:0] e_off;
        @(negedge clk);
        addr = a;
        #1;
        e_hit = 0; e_bank = 0; e_off = 0;
        for (int i = 3; i >= 0; i--) begin
            longint unsigned bs = longint'({exp_cfg[i][31:23], 23'b0});
            longint unsigned sz = 64'd4194304 << exp_cfg[i][19:17];
            if (ctrl_enable && exp_cfg[i][0] && longint'(a) >= bs && longint'(a) < bs + sz) begin
                e_hit = 1; e_bank = 2'(i); e_off = 32'(longint'(a) - bs);
            end
        end
        vectors++;
        if (hit !== e_hit || hit_bank !== e_bank || hit_offset !== e_off) begin
            errors++;
            $display("FAIL %s addr %h: got hit=%0b bank=%0d off=%h expected hit=%0b bank=%0d off=%h",
                     tag, a, hit, hit_bank, hit_offset, e_hit, e_bank, e_off);
        end
    endtask

    task automatic sweep(input string tag);
        for (int k = 0; k < 4096; k++) begin
            chk_addr(tag, (32'(k) << 20) | ((32'(k) * 32'd40503) & 32'h000F_FFFF));
        end
        for (int i = 0; i < 4; i++) begin
            logic [31:0] bs = {exp_cfg[i][31:23], 23'b0};
            logic [31:0] ed = bs + (32'd4194304 << exp_cfg[i][19:17]);
            chk_addr(tag, bs - 1); chk_addr(tag, bs);
            chk_addr(tag, ed - 1); chk_addr(tag, ed);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000) begin
                errors++;
                $display("FAIL watchdog expired");
                $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
                $finish;
            end
        end
    end

    initial begin
        for (int i = 0; i < 4; i++) exp_cfg[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        ctrl_enable = 1'b1;
        // R1: reset state
        for (int i = 0; i < 4; i++) chk_rd("R1", i, 32'h0);
        chk_addr("R1", 32'h0000_0000);
        chk_addr("R1", 32'h1234_5678);

        // R2: mask on store, all-ones and alternating patterns
        for (int i = 0; i < 4; i++) begin
            write_cfg(i, 32'hFFFF_FFFF);
            chk_rd("R2", i, 32'hFFDE_E001);
        end
        for (int i = 0; i < 4; i++) begin
            write_cfg(i, 32'h5A5A_A5A5 ^ 32'(i));
            chk_rd("R2", i, (32'h5A5A_A5A5 ^ 32'(i)) & MASK);
        end

        // R9: write visible only after the sampling edge
        cfg_rd_bank = 2'd2;
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_bank = 2'd2; cfg_wr_data = 32'h0000_0000;
        #1;
        vectors++;
        if (cfg_rd_data !== exp_cfg[2]) begin
            errors++;
            $display("FAIL R9 before edge: got %h expected %h", cfg_rd_data, exp_cfg[2]);
        end
        @(negedge clk);
        cfg_wr_en = 1'b0; exp_cfg[2] = 32'h0;
        chk_rd("R9", 2, 32'h0);

        // R3 R4 R8: disjoint windows including one reaching the top of space
        write_cfg(0, mkcfg(32'h0000_0000, 0, 1));
        write_cfg(1, mkcfg(32'h0080_0000, 1, 1) | 32'h0001_0000);  // stray bit 16 masked off
        write_cfg(2, mkcfg(32'h1000_0000, 6, 1));
        write_cfg(3, mkcfg(32'hFF80_0000, 3, 1));
        chk_rd("R2", 1, mkcfg(32'h0080_0000, 1, 1));
        sweep("R3_R4_R8");
        chk_addr("R3", 32'h0040_0000);   // past the wrapped bank 3 region
        chk_addr("R3", 32'hFFFF_FFFF);

        // R5: a disabled bank never hits
        write_cfg(2, mkcfg(32'h1000_0000, 6, 0));
        chk_addr("R5", 32'h1000_0000);
        chk_addr("R5", 32'h17FF_FFFF);

        // R7: overlapping windows, lowest index wins
        write_cfg(0, mkcfg(32'h0000_0000, 4, 1));   // 64 MiB
        write_cfg(1, mkcfg(32'h0080_0000, 0, 1));
        write_cfg(2, mkcfg(32'h0100_0000, 7, 1));   // 512 MiB
        write_cfg(3, mkcfg(32'h0000_0000, 5, 1));   // 128 MiB
        chk_addr("R7", 32'h0090_0000);
        chk_addr("R7", 32'h0200_0000);
        chk_addr("R7", 32'h0600_0000);
        sweep("R7");

        // R6: global gate off, then back on without rewriting
        @(negedge clk); ctrl_enable = 1'b0;
        chk_addr("R6", 32'h0000_0000);
        chk_addr("R6", 32'h0600_0000);
        for (int k = 0; k < 512; k++) chk_addr("R6", 32'(k) << 23);
        @(negedge clk); ctrl_enable = 1'b1;
        chk_addr("R6", 32'h0000_0010);
        chk_addr("R6", 32'h0600_0000);
        sweep("R6");

        // R1: reset again clears all stored words
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            exp_cfg[i] = '0;
            chk_rd("R1", i, 32'h0);
        end
        chk_addr("R1", 32'h0000_0000);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule